// File: doc/BRIEF.md
# Tick-Driven 8-bit Timer with Compare and Overflow Interrupt Flags

This block is a small timer/counter peripheral. A counter moves forward by one on each cycle where the external `tick_en` input is high. A compare register is checked against the counter on those tick cycles. When the two are equal, the block sets a compare flag and toggles a waveform pin. When the counter rolls over from its all-ones value to zero, the block sets an overflow flag.

Each flag raises its own interrupt request to an interrupt controller. A request is asserted only when the global interrupt enable, that source's mask bit and that source's flag are all high. A flag is cleared in one of two ways: software writes a one to it, or the interrupt controller returns an acknowledge pulse for that source. A hardware set always wins over a clear that lands in the same cycle.

Software reaches the block through a single-cycle register bus with a write strobe and combinational read data. A write to the counter reloads it and masks the compare on the next tick. This lets software move the counter without raising a spurious match on the value it has just loaded.

Top module: `tick_timer_cmp`

## Requirements
- R1: After reset, the counter, the compare value, the mask and the flags all read zero, both requests are low and `wave_out` is low.
- R2: Address 0 holds the counter and reads back whatever was written to it. A counter write in a cycle where `tick_en` is high loads the written value, and the counter does not advance in that cycle.
- R3: On each cycle with `tick_en` high and no counter write, the counter increments by one and wraps from 0xFF to 0x00. With `tick_en` low it holds its value.
- R4: On a tick where the counter equals the compare value held at address 1, the compare flag is set. The compare flag is bit 7 of the flag register at address 3.
- R5: After a counter write, the first tick that follows raises no compare match, however many idle cycles lie between the write and that tick.
- R6: A tick that wraps the counter from 0xFF to 0x00 sets the overflow flag, bit 6 of the flag register. No earlier tick sets it.
- R7: Writing the flag register clears each flag whose bit in the write data is one. Flags whose written bit is zero are left as they are.
- R8: A one-cycle pulse on `cmp_ack` clears the compare flag, and a one-cycle pulse on `ovf_ack` clears the overflow flag.
- R9: When a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R10: The mask register at address 2 uses bit 7 for compare and bit 6 for overflow. Its other bits read as zero. A request is high only when `glb_irq_en`, its mask bit and its flag are all one.
- R11: `wave_out` toggles once on every compare match that is not suppressed. It does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting enable for this cycle |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare, 2 mask, 3 flags |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_rdata | output | 8 | Combinational read data of the selected register |
| glb_irq_en | input | 1 | Global interrupt enable |
| cmp_ack | input | 1 | Acknowledge of the compare request |
| ovf_ack | input | 1 | Acknowledge of the overflow request |
| cmp_irq | output | 1 | Compare-match interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| wave_out | output | 1 | Waveform pin that toggles on each compare match |

## Verification
The assertions assume three things about the inputs: the bus upper address bits select only the four defined registers, an acknowledge is a single-cycle pulse, and it is sent only for a request that was raised. The bench drives every input on the falling edge. Acknowledges last one cycle. Writes go only to the four decoded addresses. The cycles that combine a tick with a flag write, or a tick with an acknowledge, are built on purpose so that the set-wins and write-wins orderings are covered.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
   typedef enum logic [1:0] {
      REG_COUNT = 2'd0,
      REG_MATCH = 2'd1,
      REG_MASK  = 2'd2,
      REG_FLAG  = 2'd3
   } reg_sel_e;

   localparam int SRC_CMP = 0;
   localparam int SRC_OVF = 1;
   localparam int NSRC    = 2;

   // bit position of an interrupt source inside the mask and flag registers
   function automatic int src_pos(input int src, input int cmp_bit, input int ovf_bit);
      return (src == SRC_CMP) ? cmp_bit : ovf_bit;
   endfunction
endpackage

// File: rtl/tt_counter.sv
`timescale 1ns/1ps
module tt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             cmp_evt,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic blk_q;   // compare masked until the next tick after a load
   logic adv;

   assign adv     = tick_en && !load;
   assign cmp_evt = adv && !blk_q && (cnt_q == cmp_val);
   assign ovf_evt = adv && (cnt_q == CNT_TOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         blk_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         blk_q <= 1'b1;
      end else if (tick_en) begin
         cnt_q <= cnt_q + 1'b1;
         blk_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tt_flag.sv
`timescale 1ns/1ps
module tt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic w1c_i,
   input  logic ack_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 1'b0;
      else if (set_i)
         q <= 1'b1;
      else if (w1c_i || ack_i)
         q <= 1'b0;
   end
endmodule

// File: rtl/tt_regs.sv
`timescale 1ns/1ps
module tt_regs
   import tick_timer_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int ADDR_W  = 2,
   parameter int CMP_BIT = 7,
   parameter int OVF_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic              bus_we,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [NSRC-1:0]   flag_q,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cmp_val,
   output logic [NSRC-1:0]   mask_q,
   output logic [NSRC-1:0]   flag_w1c,
   output logic [CNT_W-1:0]  bus_rdata
);
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_COUNT);
   localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(REG_MATCH);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(REG_FLAG);

   logic cmp_wr, mask_wr, flag_wr;
   logic [CNT_W-1:0] mask_view, flag_view;

   assign cnt_load = bus_we && (bus_addr == A_CNT);
   assign cmp_wr   = bus_we && (bus_addr == A_CMP);
   assign mask_wr  = bus_we && (bus_addr == A_MASK);
   assign flag_wr  = bus_we && (bus_addr == A_FLAG);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmp_val <= '0;
      else if (cmp_wr)
         cmp_val <= bus_wdata;
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int P = src_pos(s, CMP_BIT, OVF_BIT);

      assign flag_w1c[s] = flag_wr && bus_wdata[P];

      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[s] <= 1'b0;
         else if (mask_wr)
            mask_q[s] <= bus_wdata[P];
      end
   end

   always_comb begin
      mask_view = '0;
      flag_view = '0;
      for (int s = 0; s < NSRC; s++) begin
         mask_view[src_pos(s, CMP_BIT, OVF_BIT)] = mask_q[s];
         flag_view[src_pos(s, CMP_BIT, OVF_BIT)] = flag_q[s];
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_CNT:   bus_rdata = cnt_q;
         A_CMP:   bus_rdata = cmp_val;
         A_MASK:  bus_rdata = mask_view;
         A_FLAG:  bus_rdata = flag_view;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tick_timer_cmp.sv
`timescale 1ns/1ps
module tick_timer_cmp
   import tick_timer_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int ADDR_W  = 2,
   parameter int CMP_BIT = 7,
   parameter int OVF_BIT = 6,
   parameter bit WAVE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic              bus_we,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              glb_irq_en,
   input  logic              cmp_ack,
   input  logic              ovf_ack,
   output logic              cmp_irq,
   output logic              ovf_irq,
   output logic              wave_out
);
   if (CNT_W < 2) begin : g_bad_width
      $error("tick_timer_cmp: CNT_W must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("tick_timer_cmp: ADDR_W must be at least 2");
   end
   if (CMP_BIT >= CNT_W || OVF_BIT >= CNT_W || CMP_BIT < 0 || OVF_BIT < 0
       || CMP_BIT == OVF_BIT) begin : g_bad_bits
      $error("tick_timer_cmp: flag bit positions invalid");
   end

   logic [CNT_W-1:0] cnt_q, cmp_val;
   logic             cnt_load, cmp_evt, ovf_evt;
   logic [NSRC-1:0]  flag_q, mask_q, flag_w1c, evt_v, ack_v, irq_v;

   tt_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CMP_BIT(CMP_BIT), .OVF_BIT(OVF_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .cnt_q(cnt_q), .flag_q(flag_q),
      .cnt_load(cnt_load), .cmp_val(cmp_val), .mask_q(mask_q),
      .flag_w1c(flag_w1c), .bus_rdata(bus_rdata)
   );

   tt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .load(cnt_load), .load_val(bus_wdata), .cmp_val(cmp_val),
      .cnt_q(cnt_q), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
   );

   assign evt_v[SRC_CMP] = cmp_evt;
   assign evt_v[SRC_OVF] = ovf_evt;
   assign ack_v[SRC_CMP] = cmp_ack;
   assign ack_v[SRC_OVF] = ovf_ack;

   for (genvar s = 0; s < NSRC; s++) begin : g_flag
      tt_flag u_flag (
         .clk(clk), .rst_n(rst_n),
         .set_i(evt_v[s]), .w1c_i(flag_w1c[s]), .ack_i(ack_v[s]),
         .q(flag_q[s])
      );
      assign irq_v[s] = glb_irq_en && mask_q[s] && flag_q[s];
   end

   assign cmp_irq = irq_v[SRC_CMP];
   assign ovf_irq = irq_v[SRC_OVF];

   if (WAVE_EN) begin : g_wave
      logic wave_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            wave_q <= 1'b0;
         else if (cmp_evt)
            wave_q <= ~wave_q;
      end
      assign wave_out = wave_q;
   end else begin : g_no_wave
      assign wave_out = 1'b0;
   end
endmodule

// File: rtl/tick_timer_cmp_chk.sv
`timescale 1ns/1ps
module tick_timer_cmp_chk
   import tick_timer_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int ADDR_W  = 2,
   parameter int CMP_BIT = 7,
   parameter int OVF_BIT = 6,
   parameter bit WAVE_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  bus_wdata,
   input logic              glb_irq_en,
   input logic              cmp_ack,
   input logic              ovf_ack,
   input logic              cmp_irq,
   input logic              ovf_irq,
   input logic              wave_out,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              cmp_evt,
   input logic              ovf_evt,
   input logic [NSRC-1:0]   flag_q
);
   logic cnt_wr, flag_wr;
   logic [NSRC-1:0] evt_v, ack_v, irq_v;

   assign cnt_wr  = bus_we && (bus_addr == ADDR_W'(REG_COUNT));
   assign flag_wr = bus_we && (bus_addr == ADDR_W'(REG_FLAG));
   assign evt_v   = {ovf_evt, cmp_evt};
   assign ack_v   = {ovf_ack, cmp_ack};
   assign irq_v   = {ovf_irq, cmp_irq};

   assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(bus_wdata)));

   assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_wr) |=> $stable(cnt_q));

   assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> !cmp_evt);

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int P = src_pos(s, CMP_BIT, OVF_BIT);

      // R4 for the compare source, R6 for the overflow source; R9: set wins
      assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
         evt_v[s] |=> flag_q[s]);

      assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && bus_wdata[P] && !evt_v[s]) |=> !flag_q[s]);

      assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_v[s] && !evt_v[s]) |=> !flag_q[s]);

      assert_irq_glb_R10: assert property (@(posedge clk) disable iff (!rst_n)
         irq_v[s] |-> (glb_irq_en && flag_q[s]));
   end

   assert_ovf_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (cnt_q == '0));

   if (WAVE_EN) begin : g_wave
      assert_wave_toggle_R11: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_evt |=> (wave_out != $past(wave_out)));

      assert_wave_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !cmp_evt |=> $stable(wave_out));
   end
endmodule

bind tick_timer_cmp tick_timer_cmp_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CMP_BIT(CMP_BIT), .OVF_BIT(OVF_BIT),
   .WAVE_EN(WAVE_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .glb_irq_en(glb_irq_en), .cmp_ack(cmp_ack), .ovf_ack(ovf_ack),
   .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .wave_out(wave_out),
   .cnt_q(cnt_q), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt), .flag_q(flag_q)
);

// File: tb/tick_timer_cmp_test.sv
`timescale 1ns/1ps
module tick_timer_cmp_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_rdata;
   logic       glb_irq_en = 1'b0;
   logic       cmp_ack = 1'b0;
   logic       ovf_ack = 1'b0;
   logic       cmp_irq, ovf_irq, wave_out;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [1:0] A_CNT = 2'd0, A_CMP = 2'd1, A_MASK = 2'd2, A_FLAG = 2'd3;

   always #5 clk = ~clk;

   tick_timer_cmp uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_rdata(bus_rdata), .glb_irq_en(glb_irq_en),
      .cmp_ack(cmp_ack), .ovf_ack(ovf_ack),
      .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .wave_out(wave_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic step(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(A_CNT, v);  chk("R1 counter", v, 8'h00);
      rd(A_CMP, v);  chk("R1 compare", v, 8'h00);
      rd(A_MASK, v); chk("R1 mask", v, 8'h00);
      rd(A_FLAG, v); chk("R1 flags", v, 8'h00);
      chk("R1 requests", {6'd0, cmp_irq, ovf_irq}, 8'h00);
      chk("R1 wave", {7'd0, wave_out}, 8'h00);
   endtask

   task automatic t_count();
      logic [7:0] v;
      wr(A_CNT, 8'h10);
      rd(A_CNT, v); chk("R2 counter readback", v, 8'h10);
      step(5);
      rd(A_CNT, v); chk("R3 five ticks", v, 8'h15);
      repeat (4) @(negedge clk);
      rd(A_CNT, v); chk("R3 hold without tick", v, 8'h15);
      @(negedge clk);
      tick_en = 1'b1; bus_we = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h77;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0;
      rd(A_CNT, v); chk("R2 write beats tick", v, 8'h77);
   endtask

   task automatic t_match();
      logic [7:0] v;
      wr(A_CMP, 8'h20);
      rd(A_CMP, v); chk("R4 compare readback", v, 8'h20);
      wr(A_CNT, 8'h1E);
      step(2);
      rd(A_FLAG, v); chk("R4 no match before equal", v, 8'h00);
      chk("R11 wave before match", {7'd0, wave_out}, 8'h00);
      step(1);
      rd(A_FLAG, v); chk("R4 compare flag set", v, 8'h80);
      rd(A_CNT, v);  chk("R3 counter after match", v, 8'h21);
      chk("R11 wave toggled high", {7'd0, wave_out}, 8'h01);
   endtask

   task automatic t_irq_gate();
      logic [7:0] v;
      chk("R10 masked request", {7'd0, cmp_irq}, 8'h00);
      wr(A_MASK, 8'hFF);
      rd(A_MASK, v); chk("R10 mask unused bits zero", v, 8'hC0);
      chk("R10 global disable", {7'd0, cmp_irq}, 8'h00);
      @(negedge clk); glb_irq_en = 1'b1; #1;
      chk("R10 compare request", {7'd0, cmp_irq}, 8'h01);
      chk("R10 overflow request idle", {7'd0, ovf_irq}, 8'h00);
   endtask

   task automatic t_ack();
      logic [7:0] v;
      @(negedge clk); cmp_ack = 1'b1;
      @(negedge clk); cmp_ack = 1'b0;
      rd(A_FLAG, v); chk("R8 ack clears compare flag", v, 8'h00);
      chk("R8 request dropped", {7'd0, cmp_irq}, 8'h00);
   endtask

   task automatic t_blocked();
      logic [7:0] v;
      wr(A_CMP, 8'h40);
      wr(A_CNT, 8'h40);
      repeat (3) @(negedge clk);
      step(1);
      rd(A_FLAG, v); chk("R5 match suppressed", v, 8'h00);
      rd(A_CNT, v);  chk("R5 counter still advanced", v, 8'h41);
      chk("R5 wave unchanged", {7'd0, wave_out}, 8'h01);
   endtask

   task automatic t_overflow();
      logic [7:0] v;
      wr(A_CNT, 8'hFE);
      step(1);
      rd(A_FLAG, v); chk("R6 no early overflow", v, 8'h00);
      step(1);
      rd(A_CNT, v);  chk("R3 wrap to zero", v, 8'h00);
      rd(A_FLAG, v); chk("R6 overflow flag set", v, 8'h40);
      chk("R10 overflow request", {7'd0, ovf_irq}, 8'h01);
   endtask

   task automatic t_w1c();
      logic [7:0] v;
      wr(A_FLAG, 8'h00);
      rd(A_FLAG, v); chk("R7 zero write no effect", v, 8'h40);
      wr(A_FLAG, 8'hBF);
      rd(A_FLAG, v); chk("R7 other bits no effect", v, 8'h40);
      wr(A_FLAG, 8'h40);
      rd(A_FLAG, v); chk("R7 write one clears", v, 8'h00);
      chk("R7 request dropped", {7'd0, ovf_irq}, 8'h00);
   endtask

   task automatic t_setwins();
      logic [7:0] v;
      wr(A_CMP, 8'h51);
      wr(A_CNT, 8'h50);
      step(1);
      @(negedge clk);
      tick_en = 1'b1; bus_we = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h80;
      @(negedge clk);
      tick_en = 1'b0; bus_we = 1'b0;
      rd(A_FLAG, v); chk("R9 set beats write-one", v, 8'h80);
      rd(A_CNT, v);  chk("R3 counter after combined cycle", v, 8'h52);
      chk("R11 wave toggled back", {7'd0, wave_out}, 8'h00);
      wr(A_CNT, 8'hFF);
      @(negedge clk);
      tick_en = 1'b1; ovf_ack = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; ovf_ack = 1'b0;
      rd(A_FLAG, v); chk("R9 set beats ack", v, 8'hC0);
      @(negedge clk); ovf_ack = 1'b1;
      @(negedge clk); ovf_ack = 1'b0;
      rd(A_FLAG, v); chk("R8 overflow ack clears", v, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_match();
      t_irq_gate();
      t_ack();
      t_blocked();
      t_overflow();
      t_w1c();
      t_setwins();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errs++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule